// File: doc/BRIEF.md
# Line Signal Loss Monitor

This block watches the bit stream and clock recovered from a T1 or E1 receive line. It reports when the line has gone dead. Two independent criteria can declare the loss.

- **Zero run:** one counter measures the current run of consecutive received zeros.
- **Low level:** a timer measures how long the analog level comparator has reported a signal below its threshold. The timer counts ticks from a prescaler on the recovered clock, and one full count is one millisecond.

Once loss is declared, it stays declared until a cycle in which a one is received while the comparator reports a level above threshold.

The block also sets the threshold requested from the comparator. In T1 mode this is always the deep (-40 dB) setting. In E1 mode the threshold select input chooses between the shallow (-20 dB) and deep (-40 dB) settings.

A two-bit mask builds the alarm pin from two sources: the loss-of-signal state and an external loss-of-basic-frame-sync flag. Each source passes only when its mask bit is set. The pin is the OR of the sources that pass, so it can show either source, both, or neither.

The control is a two-state machine.
- **Carrier present (`ST_CARRIER`):** the reset state. The *declare* transition moves to `ST_LOST` when the zero run has exceeded `ZERO_LIMIT` or the level timer has expired.
- **Signal lost (`ST_LOST`):** the *restore* transition returns to `ST_CARRIER` in a cycle where `rx_bit` is 1 and `lvl_ok` is 1. Otherwise the state holds.

Top module: `los_monitor`

## Requirements
- R1: After reset, `los_status` is 0, and `alarm_pin` is 0 while `sync_lost` is 0.
- R2: When zeros are received continuously from the carrier state, `los_status` rises on the clock edge that follows the (`ZERO_LIMIT`+1)-th consecutive zero. It stays 1 for as long as the zeros continue, however long the run.
- R3: A run of at most `ZERO_LIMIT` zeros that ends in a one never declares loss of signal.
- R4: With `lvl_ok` held at 0, `los_status` rises on the edge after `REF_DIV`*`MS_TICKS` cycles of low level.
- R5: Any cycle with `lvl_ok` at 1 restarts the level timing. The next declaration then needs a full `REF_DIV`*`MS_TICKS` low cycles again.
- R6: In the lost state, a cycle with both `rx_bit`=1 and `lvl_ok`=1 clears `los_status` at that edge. A cycle lacking either condition leaves it at 1.
- R7: `thr_deep` (1 = -40 dB, 0 = -20 dB) is 1 whenever `mode_e1` is 0. When `mode_e1` is 1, it equals `thr_sel`.
- R8: `alarm_pin` = (`alarm_mask[0]` & `los_status`) | (`alarm_mask[1]` & `sync_lost`).
- R9: With `alarm_mask` = 2'b00, `alarm_pin` is 0 whatever the loss and sync states are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock, one received bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Recovered data bit (1 = mark) |
| lvl_ok | input | 1 | Comparator flag, 1 = level above threshold |
| sync_lost | input | 1 | Loss of basic frame sync from the framer |
| mode_e1 | input | 1 | 1 = E1 line, 0 = T1 line |
| thr_sel | input | 1 | E1 threshold choice, 1 = -40 dB, 0 = -20 dB |
| alarm_mask | input | 2 | Bit 0 enables loss of signal, bit 1 enables sync loss on the pin |
| los_status | output | 1 | Loss-of-signal status |
| alarm_pin | output | 1 | Masked alarm output |
| thr_deep | output | 1 | Threshold to comparator, 1 = -40 dB |

## Verification
The assertions assume the following about the inputs:
- All inputs are synchronous to `clk` and are never X once reset is released.
- `lvl_ok` and `rx_bit` reflect the bit sampled at each edge, so a rise in loss status can be traced back exactly two samples to a zero bit or a low level.

The bench keeps within these limits. It changes every input shortly after a rising edge, holds all inputs at defined values from time zero, and asserts reset for two edges before any sweep. Runs of zeros, low-level windows and mask and mode combinations are swept exhaustively around the reduced limits that the bench selects.

// File: rtl/los_pkg.sv
package los_pkg;
    typedef enum logic {
        ST_CARRIER = 1'b0,
        ST_LOST    = 1'b1
    } los_state_t;

    localparam int MASK_LOS_BIT  = 0;
    localparam int MASK_SYNC_BIT = 1;
endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
    parameter int ZERO_LIMIT = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    output logic run_over
);
    localparam int CW = $clog2(ZERO_LIMIT + 2);
    localparam logic [CW-1:0] CAP = CW'(ZERO_LIMIT + 1);

    logic [CW-1:0] run_q;

    // Run length of zeros, held once it passes the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (rx_bit) begin
            run_q <= '0;
        end else if (run_q != CAP) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign run_over = (run_q == CAP);
endmodule

// File: rtl/los_level_timer.sv
module los_level_timer #(
    parameter int REF_DIV  = 8,
    parameter int MS_TICKS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_ok,
    output logic expired
);
    localparam int PW = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
    localparam int TW = $clog2(MS_TICKS + 1);
    localparam logic [PW-1:0] PTOP = PW'(REF_DIV - 1);
    localparam logic [TW-1:0] TLIM = TW'(MS_TICKS);

    logic [PW-1:0] pre_q;
    logic [TW-1:0] ms_q;
    logic          tick;

    assign tick = (pre_q == PTOP);

    // Both the prescaler and the tick count restart on a good level.
    always_ff @(posedge clk) begin
        if (!rst_n || lvl_ok) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (ms_q != TLIM) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                ms_q <= ms_q + 1'b1;
            end
        end
    end

    assign expired = (ms_q == TLIM);
endmodule

// File: rtl/los_fsm.sv
module los_fsm
    import los_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_over,
    input  logic lvl_expired,
    input  logic rx_bit,
    input  logic lvl_ok,
    output logic los
);
    los_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CARRIER: if (run_over || lvl_expired) state_d = ST_LOST;
            ST_LOST:    if (rx_bit && lvl_ok)        state_d = ST_CARRIER;
            default:                                 state_d = ST_CARRIER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CARRIER;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        los = (state_q == ST_LOST);
    end
endmodule

// File: rtl/los_monitor.sv
module los_monitor
    import los_pkg::*;
#(
    parameter int ZERO_LIMIT = 192,
    parameter int REF_DIV    = 8,
    parameter int MS_TICKS   = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_bit,
    input  logic       lvl_ok,
    input  logic       sync_lost,
    input  logic       mode_e1,
    input  logic       thr_sel,
    input  logic [1:0] alarm_mask,
    output logic       los_status,
    output logic       alarm_pin,
    output logic       thr_deep
);
    logic run_over;
    logic lvl_expired;

    los_zero_run #(.ZERO_LIMIT(ZERO_LIMIT)) zrun_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_bit   (rx_bit),
        .run_over (run_over)
    );

    los_level_timer #(.REF_DIV(REF_DIV), .MS_TICKS(MS_TICKS)) ltmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_ok  (lvl_ok),
        .expired (lvl_expired)
    );

    los_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_over    (run_over),
        .lvl_expired (lvl_expired),
        .rx_bit      (rx_bit),
        .lvl_ok      (lvl_ok),
        .los         (los_status)
    );

    // T1 always asks for the deep threshold.
    assign thr_deep  = mode_e1 ? thr_sel : 1'b1;
    assign alarm_pin = (alarm_mask[MASK_LOS_BIT]  & los_status)
                     | (alarm_mask[MASK_SYNC_BIT] & sync_lost);
endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_bit,
    input logic       lvl_ok,
    input logic       sync_lost,
    input logic       mode_e1,
    input logic       thr_sel,
    input logic [1:0] alarm_mask,
    input logic       los_status,
    input logic       alarm_pin,
    input logic       thr_deep
);
    a_r7_t1_deep: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_e1 |-> thr_deep);

    a_r7_e1_follow: assert property (@(posedge clk) disable iff (!rst_n)
        mode_e1 |-> (thr_deep == thr_sel));

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_mask == 2'b00) |-> !alarm_pin);

    a_r8_sync_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_mask[1] && sync_lost) |-> alarm_pin);

    a_r8_los_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_mask[0] && los_status) |-> alarm_pin);

    a_r6_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (los_status && rx_bit && lvl_ok) |=> !los_status);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (los_status && !(rx_bit && lvl_ok)) |=> los_status);

    a_r2_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_status) |-> (!$past(rx_bit, 2) || !$past(lvl_ok, 2)));
endmodule

bind los_monitor los_monitor_chk chk_i (.*);

// File: tb/los_monitor_tb_top.sv
module los_monitor_tb_top;
    localparam int ZL  = 6;
    localparam int DIV = 3;
    localparam int MST = 4;
    localparam int ZDECL = ZL + 2;
    localparam int LDECL = DIV * MST + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b1;
    logic       lvl_ok = 1'b1;
    logic       sync_lost = 1'b0;
    logic       mode_e1 = 1'b0;
    logic       thr_sel = 1'b0;
    logic [1:0] alarm_mask = 2'b00;
    logic       los_status, alarm_pin, thr_deep;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    los_monitor #(.ZERO_LIMIT(ZL), .REF_DIV(DIV), .MS_TICKS(MST)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .lvl_ok(lvl_ok),
        .sync_lost(sync_lost), .mode_e1(mode_e1), .thr_sel(thr_sel),
        .alarm_mask(alarm_mask), .los_status(los_status),
        .alarm_pin(alarm_pin), .thr_deep(thr_deep)
    );

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_bit = 1'b1; lvl_ok = 1'b1;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic force_lost();
        do_reset();
        rx_bit = 1'b0;
        for (int k = 0; k < ZDECL; k++) step();
        rx_bit = 1'b1;
        lvl_ok = 1'b0;
    endtask

    initial begin
        do_reset();
        check("R1 los", los_status, 1'b0);
        alarm_mask = 2'b11;
        #1 check("R1 pin", alarm_pin, 1'b0);

        // R2: zero run, per-step comparison, with a long tail for saturation.
        do_reset();
        rx_bit = 1'b0;
        for (int k = 1; k <= 60; k++) begin
            step();
            check("R2 zero run", los_status, k >= ZDECL);
        end

        // R3: runs up to the limit closed by a one never declare.
        for (int len = 0; len <= ZL; len++) begin
            do_reset();
            rx_bit = 1'b0;
            for (int k = 0; k < len; k++) step();
            rx_bit = 1'b1;
            step(); step();
            check("R3 short run", los_status, 1'b0);
        end

        // R4: level timing sweep.
        do_reset();
        lvl_ok = 1'b0;
        for (int k = 1; k <= LDECL + 3; k++) begin
            step();
            check("R4 level low", los_status, k >= LDECL);
        end

        // R5: a single good-level cycle restarts the window.
        for (int p = 1; p < LDECL - 1; p++) begin
            do_reset();
            lvl_ok = 1'b0;
            for (int k = 0; k < p; k++) step();
            lvl_ok = 1'b1; step();
            lvl_ok = 1'b0;
            for (int k = 0; k < LDECL - 1; k++) step();
            check("R5 restart", los_status, 1'b0);
            step();
            check("R5 full window", los_status, 1'b1);
        end

        // R6: restore only on one plus good level.
        force_lost();
        step();
        check("R6 one, low level", los_status, 1'b1);
        rx_bit = 1'b0; lvl_ok = 1'b1; step();
        check("R6 zero, good level", los_status, 1'b1);
        rx_bit = 1'b1; step();
        check("R6 restore", los_status, 1'b0);
        step();
        check("R6 stays clear", los_status, 1'b0);

        // R7: threshold for all mode/select pairs.
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 2; s++) begin
                mode_e1 = m[0]; thr_sel = s[0];
                #1 check("R7 threshold", thr_deep, m[0] ? s[0] : 1'b1);
            end
        end

        // R8, R9: mask, loss and sync combinations.
        for (int l = 0; l < 2; l++) begin
            if (l == 0) begin
                do_reset();
            end else begin
                force_lost();
                step();
            end
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < 2; s++) begin
                    alarm_mask = m[1:0]; sync_lost = s[0];
                    #1;
                    if (m == 0)
                        check("R9 masked", alarm_pin, 1'b0);
                    else
                        check("R8 pin", alarm_pin,
                              (m[0] & l[0]) | (m[1] & s[0]));
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule